// File: doc/BRIEF.md
# Chained Two-Dimensional Block Copy Engine

This block is the transfer engine of a single memory-to-memory copy channel. Software places a chain of six-word control blocks in memory and pulses `start` with the address of the first one. The engine reads the six words, copies 32-bit words from a source address to a destination address, and then moves on to the next control block. The chain ends when a next-block address of zero is reached, or when `chan_en` is low at the end of a block. Each copy is either one linear run or a two-dimensional block of rows. In the two-dimensional case, signed row strides are added to both addresses between rows. For each side there is a flag that advances its address after every word and a flag that suppresses its memory traffic.

All memory traffic goes through one master port with a valid/ready handshake. Only one request is outstanding at a time. A request is presented with `mem_valid` and holds its address, direction and write data unchanged until `mem_ready` is seen high at a clock edge. Read data is taken from `mem_rdata` in that same cycle. The memory may hold `mem_ready` low for any number of cycles, and that is the only back-pressure. The engine raises a one-cycle completion event after each control block, qualified by that block's interrupt-enable bit. The live control-block words, the working addresses and the remaining count are visible on read-back outputs.

Top module: `dma2d_engine`

## Requirements
- R1: On an accepted start, the engine issues six reads at the control-block address plus 0, 4, 8, 12, 16 and 20, in that order, taking in turn the flags word, source address, destination address, length word, stride word and next-block address. The read-back outputs then show those words.
- R2: In linear mode (flags bit 1 clear), a length of N bytes, N a multiple of 4, gives N/4 word beats. Each beat reads a word from the source address and writes it to the destination address.
- R3: After each beat, the source address advances by 4 only if flags bit 8 is set, and the destination address advances by 4 only if flags bit 4 is set. Otherwise the address stays where it is.
- R4: With flags bit 11 set, no source read is issued and the word written is zero. With flags bit 7 set, no destination write is issued.
- R5: In 2D mode (flags bit 1 set), the row count is length[29:16] and the bytes per row are length[15:0]. After every row but the last, signed stride[31:16] is added to the destination address and signed stride[15:0] is added to the source address.
- R6: The read-back length shows the remaining byte count after each beat. In 2D mode it is packed as {rows remaining including the current row, 16-bit bytes remaining}.
- R7: At the end of each control block, `done` is high for exactly one cycle, and `done_irq` is high in that cycle exactly when flags bit 0 is set.
- R8: After a block, the next-block address becomes the current address. The engine fetches it when it is nonzero and `chan_en` is high. Otherwise it returns to idle with `busy` low. A start with address zero does nothing.
- R9: `chan_en` is sampled only at start and between blocks. A block in progress when `chan_en` falls completes fully. A `start` while busy, or while `chan_en` is low, is ignored.
- R10: A linear length of zero, a 2D row count of zero, or a 2D row length of zero completes the block with no data reads or writes.
- R11: While `mem_valid` is high and `mem_ready` is low, the request (address, direction, write data) stays unchanged in the next cycle. Wait states do not change the data moved.
- R12: After reset, `busy`, `mem_valid`, `done` and all read-back outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain at `cb_addr_in` (accepted only when idle and enabled) |
| cb_addr_in | input | 32 | Byte address of the first control block |
| chan_en | input | 1 | Channel enable, sampled at start and between blocks |
| busy | output | 1 | Engine is processing a chain |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle of a read |
| done | output | 1 | One-cycle control-block completion event |
| done_irq | output | 1 | Interrupt-enable bit of the completed block, valid with `done` |
| live_cb | output | 32 | Current control-block address |
| live_flags | output | 32 | Flags word of the current block |
| live_src | output | 32 | Working source address |
| live_dst | output | 32 | Working destination address |
| live_len | output | 32 | Remaining length |
| live_stride | output | 32 | Stride word |
| live_next | output | 32 | Next-block address |

## Verification
Two events can meet in one cycle: the end of a control block, where the chain decision samples `chan_en`, and an outside change of `chan_en` or a fresh `start`. The bench drops `chan_en` in the middle of a two-block chain. It then checks that the first block is written completely, that the second block's destination is untouched and that `live_cb` holds the second block's address. It also pulses `start` with a harmful control-block address while a chain runs and checks that this target area keeps its sentinel. Wait states of two cycles out of three are inserted during a 2D copy with a negative source stride, so the handshake hold coincides with row changes.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int WORD_W   = 32;
  localparam int CB_WORDS = 6;
  localparam int IDX_W    = $clog2(CB_WORDS);
  localparam int ROW_W    = 16;

  // flag bit positions decoded from the first control-block word
  localparam int F_IRQ    = 0;
  localparam int F_2D     = 1;
  localparam int F_DINC   = 4;
  localparam int F_DSKIP  = 7;
  localparam int F_SINC   = 8;
  localparam int F_SSKIP  = 11;

  // word order inside a control block
  localparam int W_FLAGS  = 0;
  localparam int W_SRC    = 1;
  localparam int W_DST    = 2;
  localparam int W_LEN    = 3;
  localparam int W_STRIDE = 4;
  localparam int W_NEXT   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_ROW, ST_READ, ST_WRITE, ST_ROWEND, ST_DONE
  } eng_state_t;

  function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
    return {{(WORD_W-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/dma2d_desc_regs.sv
module dma2d_desc_regs
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [WORD_W-1:0] load_word,
  input  logic              cb_set,
  input  logic [WORD_W-1:0] cb_value,
  input  logic              src_adv,
  input  logic              dst_adv,
  input  logic              row_adv,
  input  logic              len_upd,
  input  logic [WORD_W-1:0] len_value,
  output logic [WORD_W-1:0] cb_q,
  output logic [WORD_W-1:0] flags_q,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] dst_q,
  output logic [WORD_W-1:0] len_q,
  output logic [WORD_W-1:0] stride_q,
  output logic [WORD_W-1:0] next_q
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  logic [WORD_W-1:0] src_step, dst_step;

  always_comb begin
    src_step = flags_q[F_SINC] ? STEP : '0;
    dst_step = flags_q[F_DINC] ? STEP : '0;
    if (row_adv) begin
      src_step = sext16(stride_q[15:0]);
      dst_step = sext16(stride_q[31:16]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_q <= '0; flags_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; stride_q <= '0; next_q <= '0;
    end else begin
      if (cb_set) cb_q <= cb_value;
      if (load_en) begin
        case (load_idx)
          IDX_W'(W_FLAGS):  flags_q  <= load_word;
          IDX_W'(W_SRC):    src_q    <= load_word;
          IDX_W'(W_DST):    dst_q    <= load_word;
          IDX_W'(W_LEN):    len_q    <= load_word;
          IDX_W'(W_STRIDE): stride_q <= load_word;
          default:          next_q   <= load_word;
        endcase
      end
      if (src_adv || row_adv) src_q <= src_q + src_step;
      if (dst_adv || row_adv) dst_q <= dst_q + dst_step;
      if (len_upd) len_q <= len_value;
    end
  end

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_adv && !row_adv && !load_en && !flags_q[F_SINC]) |=> $stable(src_q));

  // R3
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_adv && !row_adv && !load_en && !flags_q[F_DINC]) |=> $stable(dst_q));
endmodule

// File: rtl/dma2d_row_ctr.sv
module dma2d_row_ctr
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup,
  input  logic              mode_2d,
  input  logic [WORD_W-1:0] len_word,
  input  logic              row_start,
  input  logic              beat,
  input  logic              row_done,
  output logic              row_empty,
  output logic              beat_last,
  output logic              last_row,
  output logic [WORD_W-1:0] len_after_beat
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  logic              mode_q;
  logic [ROW_W-1:0]  rows_left;
  logic [WORD_W-1:0] row_bytes, xlen, xnext;

  assign beat_last = (xlen <= STEP);
  assign xnext     = beat_last ? '0 : xlen - STEP;
  assign row_empty = (row_bytes == '0);
  assign last_row  = (rows_left == ROW_W'(1));
  assign len_after_beat = mode_q ? {rows_left, xnext[15:0]} : xnext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0; rows_left <= '0; row_bytes <= '0; xlen <= '0;
    end else begin
      if (setup) begin
        mode_q    <= mode_2d;
        rows_left <= mode_2d ? {2'b00, len_word[29:16]} : ROW_W'(1);
        row_bytes <= mode_2d ? {16'h0000, len_word[15:0]} : len_word;
      end
      if (row_start) xlen <= row_bytes;
      else if (beat) xlen <= xnext;
      if (row_done && rows_left != '0) rows_left <= rows_left - ROW_W'(1);
    end
  end

  // R6
  xlen_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !row_start && !setup) |=> (xlen < $past(xlen) || xlen == '0));
endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine
  import dma2d_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cb_addr_in,
  input  logic        chan_en,
  output logic        busy,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        done_irq,
  output logic [31:0] live_cb,
  output logic [31:0] live_flags,
  output logic [31:0] live_src,
  output logic [31:0] live_dst,
  output logic [31:0] live_len,
  output logic [31:0] live_stride,
  output logic [31:0] live_next
);
  eng_state_t state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] data_q, len_after;
  logic src_skip, dst_skip, fetch_ack, rd_ack, wr_ack, start_ok, chain_go;
  logic row_empty, beat_last, last_row;

  assign src_skip  = live_flags[F_SSKIP];
  assign dst_skip  = live_flags[F_DSKIP];
  assign fetch_ack = (state_q == ST_FETCH) && mem_ready;
  assign rd_ack    = (state_q == ST_READ)  && (src_skip || mem_ready);
  assign wr_ack    = (state_q == ST_WRITE) && (dst_skip || mem_ready);
  assign start_ok  = (state_q == ST_IDLE) && start && chan_en && (cb_addr_in != '0);
  assign chain_go  = (live_next != '0) && chan_en;

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign done_irq  = done && live_flags[F_IRQ];
  assign mem_valid = (state_q == ST_FETCH) ||
                     (state_q == ST_READ  && !src_skip) ||
                     (state_q == ST_WRITE && !dst_skip);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_wdata = data_q;

  always_comb begin
    case (state_q)
      ST_FETCH: mem_addr = live_cb + {{(WORD_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
      ST_READ:  mem_addr = live_src;
      default:  mem_addr = live_dst;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_ok) state_d = ST_FETCH;
      ST_FETCH:  if (fetch_ack && idx_q == IDX_W'(CB_WORDS-1)) state_d = ST_SETUP;
      ST_SETUP:  state_d = (live_flags[F_2D] && live_len[29:16] == '0) ? ST_DONE : ST_ROW;
      ST_ROW:    state_d = row_empty ? ST_ROWEND : ST_READ;
      ST_READ:   if (rd_ack) state_d = ST_WRITE;
      ST_WRITE:  if (wr_ack) state_d = beat_last ? ST_ROWEND : ST_READ;
      ST_ROWEND: state_d = last_row ? ST_DONE : ST_ROW;
      ST_DONE:   state_d = chain_go ? ST_FETCH : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE || state_q == ST_DONE) idx_q <= '0;
      else if (fetch_ack) idx_q <= idx_q + IDX_W'(1);
      if (rd_ack) data_q <= src_skip ? '0 : mem_rdata;
    end
  end

  dma2d_desc_regs u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (fetch_ack),
    .load_idx  (idx_q),
    .load_word (mem_rdata),
    .cb_set    (start_ok || state_q == ST_DONE),
    .cb_value  (start_ok ? cb_addr_in : live_next),
    .src_adv   (rd_ack),
    .dst_adv   (wr_ack),
    .row_adv   (state_q == ST_ROWEND && !last_row),
    .len_upd   (wr_ack),
    .len_value (len_after),
    .cb_q      (live_cb),
    .flags_q   (live_flags),
    .src_q     (live_src),
    .dst_q     (live_dst),
    .len_q     (live_len),
    .stride_q  (live_stride),
    .next_q    (live_next)
  );

  dma2d_row_ctr u_rows (
    .clk            (clk),
    .rst_n          (rst_n),
    .setup          (state_q == ST_SETUP),
    .mode_2d        (live_flags[F_2D]),
    .len_word       (live_len),
    .row_start      (state_q == ST_ROW),
    .beat           (wr_ack),
    .row_done       (state_q == ST_ROWEND),
    .row_empty      (row_empty),
    .beat_last      (beat_last),
    .last_row       (last_row),
    .len_after_beat (len_after)
  );

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  // R4
  dst_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> !live_flags[F_DSKIP]);

  // R4
  src_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && state_q == ST_READ) |-> !live_flags[F_SSKIP]);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && live_next == '0) |=> !busy);
endmodule

// File: tb/dma2d_engine_bench.sv
module dma2d_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cb_addr_in = '0;
  logic        chan_en = 1'b1;
  logic        busy, mem_valid, mem_we, done, done_irq;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] live_cb, live_flags, live_src, live_dst, live_len, live_stride, live_next;

  logic [31:0] mem [0:1023];
  int errors = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, irq_cnt = 0, cyc = 0;
  int wait_mode = 0;
  logic [31:0] rd_log [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2d_engine u_dma2d_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cb_addr_in(cb_addr_in),
    .chan_en(chan_en), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .done_irq(done_irq),
    .live_cb(live_cb), .live_flags(live_flags), .live_src(live_src),
    .live_dst(live_dst), .live_len(live_len), .live_stride(live_stride),
    .live_next(live_next)
  );

  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (wait_mode != 0) ? (cyc % 3 == 2) : 1'b1;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_log[rd_cnt % 64] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (rst_n && done) done_cnt <= done_cnt + 1;
    if (rst_n && done_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_cb(input logic [31:0] a, input logic [31:0] fl, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] ln,
                        input logic [31:0] st, input logic [31:0] nx);
    mem[a[11:2]]     = fl;  mem[a[11:2] + 1] = s;  mem[a[11:2] + 2] = d;
    mem[a[11:2] + 3] = ln;  mem[a[11:2] + 4] = st; mem[a[11:2] + 5] = nx;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; irq_cnt = 0;
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk);
    cb_addr_in = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 busy", {31'b0, busy}, 0);
    chk("R12 mem_valid", {31'b0, mem_valid}, 0);
    chk("R12 done", {31'b0, done}, 0);
    chk("R12 live_len", live_len, 0);
    chk("R12 live_src", live_src, 0);
    chk("R12 live_cb", live_cb, 0);
  endtask

  task automatic t_linear();
    for (int i = 0; i < 4; i++) mem[(12'h200 >> 2) + i] = 32'hA0000000 + i;
    put_cb(32'h100, 32'h111, 32'h200, 32'h300, 16, 0, 0);
    clear_counts();
    pulse_start(32'h100);
    wait_idle();
    for (int i = 0; i < 6; i++) chk("R1 fetch order", rd_log[i], 32'h100 + 4 * i);
    chk("R1 live_flags", live_flags, 32'h111);
    for (int i = 0; i < 4; i++) chk("R2 copied word", mem[(12'h300 >> 2) + i], 32'hA0000000 + i);
    chk("R2 reads", rd_cnt, 10);
    chk("R2 writes", wr_cnt, 4);
    chk("R3 src advanced", live_src, 32'h210);
    chk("R3 dst advanced", live_dst, 32'h310);
    chk("R6 linear len", live_len, 0);
    chk("R7 done count", done_cnt, 1);
    chk("R7 irq count", irq_cnt, 1);
  endtask

  task automatic t_fixed_addr();
    mem[12'h380 >> 2] = 32'h0;
    put_cb(32'h140, 32'h000, 32'h200, 32'h380, 12, 0, 0);
    clear_counts();
    pulse_start(32'h140);
    wait_idle();
    chk("R3 fixed dst word", mem[12'h380 >> 2], 32'hA0000000);
    chk("R3 fixed src", live_src, 32'h200);
    chk("R3 fixed dst", live_dst, 32'h380);
    chk("R2 fixed reads", rd_cnt, 9);
    chk("R7 no irq", irq_cnt, 0);
    chk("R7 done once", done_cnt, 1);
  endtask

  task automatic t_skip();
    mem[12'h3c0 >> 2] = 32'h11111111; mem[(12'h3c0 >> 2) + 1] = 32'h22222222;
    put_cb(32'h180, 32'h910, 32'h200, 32'h3c0, 8, 0, 0);
    clear_counts();
    pulse_start(32'h180);
    wait_idle();
    chk("R4 src skip zero 0", mem[12'h3c0 >> 2], 0);
    chk("R4 src skip zero 1", mem[(12'h3c0 >> 2) + 1], 0);
    chk("R4 src skip no reads", rd_cnt, 6);
    chk("R3 src inc under skip", live_src, 32'h208);
    mem[12'h3e0 >> 2] = 32'hDEAD0001; mem[(12'h3e0 >> 2) + 1] = 32'hDEAD0002;
    put_cb(32'h1c0, 32'h190, 32'h200, 32'h3e0, 8, 0, 0);
    clear_counts();
    pulse_start(32'h1c0);
    wait_idle();
    chk("R4 dst skip no writes", wr_cnt, 0);
    chk("R4 dst skip kept", mem[12'h3e0 >> 2], 32'hDEAD0001);
    chk("R4 dst skip reads", rd_cnt, 8);
  endtask

  task automatic t_2d();
    for (int i = 0; i < 12; i++) mem[(12'h220 >> 2) + i] = 32'hB0000000 + i;
    for (int i = 0; i < 12; i++) mem[(12'h400 >> 2) + i] = 32'h5E5E5E5E;
    put_cb(32'h600, 32'h112, 32'h240, 32'h400, 32'h00030008, 32'h0008FFE8, 0);
    wait_mode = 1;
    clear_counts();
    pulse_start(32'h600);
    wait_idle();
    wait_mode = 0;
    chk("R5 row0 w0", mem[12'h400 >> 2], 32'hB0000008);
    chk("R5 row0 w1", mem[12'h404 >> 2], 32'hB0000009);
    chk("R5 gap untouched", mem[12'h408 >> 2], 32'h5E5E5E5E);
    chk("R5 row1 w0", mem[12'h410 >> 2], 32'hB0000004);
    chk("R5 row1 w1", mem[12'h414 >> 2], 32'hB0000005);
    chk("R5 row2 w0", mem[12'h420 >> 2], 32'hB0000000);
    chk("R11 row2 w1 waits", mem[12'h424 >> 2], 32'hB0000001);
    chk("R5 final src", live_src, 32'h228);
    chk("R5 final dst", live_dst, 32'h428);
    chk("R6 packed len", live_len, 32'h00010000);
    chk("R11 writes", wr_cnt, 6);
  endtask

  task automatic t_chain_and_busy_start();
    mem[12'h700 >> 2] = 32'h0; mem[12'h740 >> 2] = 32'h0; mem[(12'h740 >> 2) + 1] = 32'h0;
    mem[12'h6c0 >> 2] = 32'h77777777;
    put_cb(32'h500, 32'h111, 32'h200, 32'h700, 4, 0, 32'h520);
    put_cb(32'h520, 32'h110, 32'h204, 32'h740, 8, 0, 0);
    put_cb(32'h5c0, 32'h111, 32'h200, 32'h6c0, 4, 0, 0);
    clear_counts();
    pulse_start(32'h500);
    repeat (3) @(negedge clk);
    start = 1'b1; cb_addr_in = 32'h5c0;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R8 first block", mem[12'h700 >> 2], 32'hA0000000);
    chk("R8 second block w0", mem[12'h740 >> 2], 32'hA0000001);
    chk("R8 second block w1", mem[12'h744 >> 2], 32'hA0000002);
    chk("R8 cb after chain", live_cb, 0);
    chk("R7 chain done", done_cnt, 2);
    chk("R7 chain irq", irq_cnt, 1);
    chk("R9 busy start ignored", mem[12'h6c0 >> 2], 32'h77777777);
  endtask

  task automatic t_disable();
    mem[12'h780 >> 2] = 32'h0; mem[12'h7c0 >> 2] = 32'h99999999;
    put_cb(32'h800, 32'h110, 32'h200, 32'h780, 16, 0, 32'h840);
    put_cb(32'h840, 32'h110, 32'h200, 32'h7c0, 4, 0, 0);
    wait_mode = 1;
    clear_counts();
    pulse_start(32'h800);
    repeat (5) @(negedge clk);
    chan_en = 1'b0;
    wait_idle();
    wait_mode = 0;
    chk("R9 block finished", mem[(12'h780 >> 2) + 3], 32'hA0000003);
    chk("R9 next not run", mem[12'h7c0 >> 2], 32'h99999999);
    chk("R8 cb holds next", live_cb, 32'h840);
    chk("R9 one done", done_cnt, 1);
    clear_counts();
    pulse_start(32'h840);
    chk("R9 disabled start", {31'b0, busy}, 0);
    repeat (3) @(negedge clk);
    chk("R9 disabled no reads", rd_cnt, 0);
    chan_en = 1'b1;
    clear_counts();
    pulse_start(32'h0);
    chk("R8 zero start", {31'b0, busy}, 0);
    repeat (3) @(negedge clk);
    chk("R8 zero start no reads", rd_cnt, 0);
  endtask

  task automatic t_zero_len();
    put_cb(32'h880, 32'h111, 32'h200, 32'h300, 0, 0, 32'h8c0);
    put_cb(32'h8c0, 32'h113, 32'h200, 32'h300, 32'h00020000, 0, 32'h900);
    put_cb(32'h900, 32'h113, 32'h200, 32'h300, 32'h00000010, 0, 0);
    clear_counts();
    pulse_start(32'h880);
    wait_idle();
    chk("R10 no writes", wr_cnt, 0);
    chk("R10 fetch reads only", rd_cnt, 18);
    chk("R10 three dones", done_cnt, 3);
    chk("R10 src unchanged", live_src, 32'h200);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_linear();
    t_fixed_addr();
    t_skip();
    t_2d();
    t_chain_and_busy_start();
    t_disable();
    t_zero_len();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule